// File: doc/BRIEF.md
# I2C Write-Completion Poller

This block is the sequencer an I2C master uses after it has finished a write to a slave memory and sent the Stop. A slave with an internally-timed write does not acknowledge its address while that write is still in progress. The poller probes the slave by sending a Start and the slave's control byte with the direction bit at 0. It reads the ninth-clock acknowledge. If there is no acknowledge, it probes again, either after a Stop or through a repeated Start, as a parameter selects. The next command can therefore begin as soon as the slave is ready, with no fixed worst-case wait.

The sequencer has eight states:

- **IDLE**: the bus is free. `start_i` moves it to START.
- **HELD**: the bus is owned with SCL low. `start_i` moves it to RSTART.
- **START** and **RSTART**: each lasts four quarters and then moves to BITS.
- **BITS**: sends the eight control bits and then the acknowledge bit. At the end of the ninth bit it moves to ACKED on an acknowledge. On a missing acknowledge it moves to STOP if that was the last permitted try or if the Stop mode is set; otherwise it moves to RSTART.
- **STOP**: lasts four quarters, then moves to GIVEUP if the retries are spent, or to START otherwise.
- **ACKED**: lasts one clock and moves to HELD.
- **GIVEUP**: lasts one clock and moves to IDLE.

A divider of `DIV` clocks sets the length of one quarter of an SCL period. SDA is open-drain: `sda_oe_o` high pulls the line low.

Top module: `i2c_ack_poller`

## Requirements
- R1: While reset is held, and afterwards until `start_i`, `scl_o` is 1 and `sda_oe_o`, `done_o` and `timeout_o` are 0.
- R2: An accepted `start_i` starts a Start condition in the next clock. Each quarter lasts `DIV` clocks. The Start quarters, as (SCL, sda_oe), are (1,0), (1,0), (1,1), (0,1). Next come the eight bits of {SLAVE_ADDR, 0}, most significant bit first. Each bit has quarters SCL 0, 0, 1, 1. A 1 bit has `sda_oe_o` = 0 and a 0 bit has `sda_oe_o` = 1, held through the whole bit.
- R3: During the ninth bit, `sda_oe_o` is 0. The line is sampled on the last clock of the third quarter, and a low level counts as an acknowledge.
- R4: On an acknowledge, `done_o` is 1 for exactly the one clock after the ninth bit. The bus is then held with SCL 0 and SDA released, and no Stop is sent, until the next `start_i`.
- R5: With `STOP_BETWEEN` = 1, a missing acknowledge (not the last try) is followed by Stop quarters (0,0), (0,1), (1,1), (1,0) and then a new Start as in R2.
- R6: With `STOP_BETWEEN` = 0, a missing acknowledge (not the last try) is followed directly by repeated-Start quarters (0,0), (1,0), (1,1), (0,1) and the control byte.
- R7: After the `MAX_TRIES`-th missing acknowledge, the Stop quarters of R5 are sent. Then `timeout_o` is 1 for one clock with SCL 1 and SDA released, and the block returns to idle.
- R8: `start_i` has no effect while a poll is in progress.
- R9: `start_i` in the held state begins the poll with the repeated-Start quarters of R6.
- R10: Every accepted `start_i` restarts the retry count, so a new poll sequence always gets `MAX_TRIES` probes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a poll sequence (accepted in idle or held state) |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL level |
| sda_oe_o | output | 1 | SDA pull-down enable (1 drives the line low) |
| done_o | output | 1 | One-clock pulse: slave acknowledged |
| timeout_o | output | 1 | One-clock pulse: retry limit reached |

## Verification
A wrong state register, quarter counter or bit index shows at once as a wrong SCL or SDA level. A reference model that predicts every clock catches it within `DIV` clocks of the first misplaced quarter. A retry counter that is off by one produces an extra or a missing probe, which becomes visible at the end of the last ninth bit as a Stop followed by a timeout pulse at the wrong clock. A wrong acknowledge sample shows as a missing `done_o` pulse one clock after the ninth bit.

// File: rtl/i2cpoll_pkg.sv
package i2cpoll_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_RSTART,
        S_BITS,
        S_STOP,
        S_ACKED,
        S_GIVEUP,
        S_HELD
    } poll_state_t;
endpackage

// File: rtl/i2cpoll_tick.sv
module i2cpoll_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cpoll_retry.sv
module i2cpoll_retry #(
    parameter int MAX_TRIES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last,
    output logic spent
);
    localparam int RW = $clog2(MAX_TRIES + 1);

    logic [RW-1:0] tries;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tries <= '0;
        else if (clear) tries <= '0;
        else if (bump)  tries <= tries + 1'b1;
    end

    assign last  = (tries == RW'(MAX_TRIES - 1));
    assign spent = (tries == RW'(MAX_TRIES));
endmodule

// File: rtl/i2c_ack_poller.sv
module i2c_ack_poller
    import i2cpoll_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR   = 7'h50,
    parameter int         DIV          = 4,
    parameter int         MAX_TRIES    = 8,
    parameter bit         STOP_BETWEEN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_oe_o,
    output logic done_o,
    output logic timeout_o
);
    localparam logic [7:0] CTRL    = {SLAVE_ADDR, 1'b0};
    localparam logic [3:0] ACK_BIT = 4'd8;

    poll_state_t state, nstate;
    logic [1:0]  ph;
    logic [3:0]  bidx;
    logic        ack_q;
    logic        tick, run, phase_end;
    logic        last, spent, clear, bump;
    logic [7:0]  ctrl_sh;

    assign run       = (state == S_START) || (state == S_RSTART) ||
                       (state == S_BITS)  || (state == S_STOP);
    assign phase_end = tick && (ph == 2'd3);
    assign clear     = ((state == S_IDLE) || (state == S_HELD)) && start_i;
    assign bump      = (state == S_BITS) && phase_end && (bidx == ACK_BIT) && !ack_q;
    assign ctrl_sh   = CTRL << bidx;

    i2cpoll_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    i2cpoll_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(clear),
        .bump (bump),
        .last (last),
        .spent(spent)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (start_i) nstate = S_START;
            S_HELD:   if (start_i) nstate = S_RSTART;
            S_START,
            S_RSTART: if (phase_end) nstate = S_BITS;
            S_BITS: begin
                if (phase_end && bidx == ACK_BIT) begin
                    if (ack_q)             nstate = S_ACKED;
                    else if (last)         nstate = S_STOP;
                    else if (STOP_BETWEEN) nstate = S_STOP;
                    else                   nstate = S_RSTART;
                end
            end
            S_STOP:   if (phase_end) nstate = spent ? S_GIVEUP : S_START;
            S_ACKED:  nstate = S_HELD;
            S_GIVEUP: nstate = S_IDLE;
            default:  nstate = S_IDLE;
        endcase
    end

    // state register, quarter and bit counters, acknowledge sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ph    <= 2'd0;
            bidx  <= 4'd0;
            ack_q <= 1'b0;
        end else begin
            state <= nstate;
            if (!run)     ph <= 2'd0;
            else if (tick) ph <= ph + 2'd1;
            if (state != S_BITS) bidx <= 4'd0;
            else if (phase_end)  bidx <= bidx + 4'd1;
            if (state == S_BITS && tick && ph == 2'd2 && bidx == ACK_BIT)
                ack_q <= !sda_i;
        end
    end

    // outputs
    always_comb begin
        scl_o     = 1'b1;
        sda_oe_o  = 1'b0;
        done_o    = 1'b0;
        timeout_o = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_HELD:   scl_o = 1'b0;
            S_ACKED: begin
                scl_o  = 1'b0;
                done_o = 1'b1;
            end
            S_GIVEUP: timeout_o = 1'b1;
            S_START: begin
                scl_o    = (ph != 2'd3);
                sda_oe_o = ph[1];
            end
            S_RSTART: begin
                scl_o    = (ph == 2'd1) || (ph == 2'd2);
                sda_oe_o = ph[1];
            end
            S_BITS: begin
                scl_o    = ph[1];
                sda_oe_o = (bidx == ACK_BIT) ? 1'b0 : !ctrl_sh[7];
            end
            S_STOP: begin
                scl_o    = ph[1];
                sda_oe_o = (ph == 2'd1) || (ph == 2'd2);
            end
            default: ;
        endcase
    end

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !scl_o && !sda_oe_o));

    assert_done_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ack_q);

    assert_timeout_spent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> spent);

    assert_sda_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BITS && $past(state) == S_BITS && scl_o && $past(scl_o))
            |-> $stable(sda_oe_o));

    assert_start_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && (state == S_START || state == S_RSTART)) |-> scl_o);

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BITS && !tick) |=> (state == S_BITS));
endmodule

// File: tb/tb_i2c_ack_poller.sv
`timescale 1ns/1ps
module tb_i2c_ack_poller;
    localparam int         DIV   = 2;
    localparam int         TRIES = 4;
    localparam logic [6:0] ADDR  = 7'h50;
    localparam logic [7:0] CTRL  = {ADDR, 1'b0};

    typedef struct packed {
        logic       scl;
        logic       oe;
        logic       dn;
        logic       to;
        logic       slv;
        logic [3:0] tag;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st0 = 1'b0, st1 = 1'b0;
    logic sl0 = 1'b0, sl1 = 1'b0;
    logic scl0, oe0, dn0, to0, scl1, oe1, dn1, to1;
    wire  sda0 = !(oe0 || sl0);
    wire  sda1 = !(oe1 || sl1);

    ent_t  q0[$];
    ent_t  q1[$];
    bit    held0 = 1'b0, held1 = 1'b0;
    string note = "";
    int    checks = 0, fails = 0;
    bit    ended = 1'b0;

    always #2.5 clk = ~clk;

    i2c_ack_poller #(.SLAVE_ADDR(ADDR), .DIV(DIV), .MAX_TRIES(TRIES), .STOP_BETWEEN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(st0), .sda_i(sda0),
        .scl_o(scl0), .sda_oe_o(oe0), .done_o(dn0), .timeout_o(to0));

    i2c_ack_poller #(.SLAVE_ADDR(ADDR), .DIV(DIV), .MAX_TRIES(TRIES), .STOP_BETWEEN(1'b0)) dut_rs (
        .clk(clk), .rst_n(rst_n), .start_i(st1), .sda_i(sda1),
        .scl_o(scl1), .sda_oe_o(oe1), .done_o(dn1), .timeout_o(to1));

    function automatic string tname(int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  10: return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic put(int m, bit scl, bit oe, bit dn, bit to, bit slv, int tag, int n);
        ent_t e;
        e.scl = scl; e.oe = oe; e.dn = dn; e.to = to; e.slv = slv; e.tag = 4'(tag);
        for (int i = 0; i < n; i++) begin
            if (m == 0) q0.push_back(e);
            else        q1.push_back(e);
        end
    endtask

    task automatic quarters(int m, bit s0, bit o0, bit s1, bit o1, bit s2, bit o2,
                            bit s3, bit o3, bit slv, int tag);
        put(m, s0, o0, 0, 0, slv, tag, DIV);
        put(m, s1, o1, 0, 0, slv, tag, DIV);
        put(m, s2, o2, 0, 0, slv, tag, DIV);
        put(m, s3, o3, 0, 0, slv, tag, DIV);
    endtask

    // behavioural expectation of one whole poll sequence
    task automatic gen(int m, int ack_poll, int tag_over);
        bit from_held = (m == 0) ? held0 : held1;
        put(m, !from_held, 0, 0, 0, 0, 1, 1);
        for (int p = 1; p <= TRIES; p++) begin
            bit hdr_rs = (p == 1) ? from_held : (m == 1);
            int tg = (p == 1) ? (from_held ? 9 : 2) : (m == 1 ? 6 : 5);
            bit ack = (p == ack_poll);
            if (tag_over != 0) tg = tag_over;
            quarters(m, !hdr_rs, 0, 1, 0, 1, 1, 0, 1, 0, tg);
            for (int b = 0; b < 8; b++) begin
                bit oe = !CTRL[7 - b];
                quarters(m, 0, oe, 0, oe, 1, oe, 1, oe, 0, tag_over != 0 ? tag_over : 2);
            end
            quarters(m, 0, 0, 0, 0, 1, 0, 1, 0, ack, tag_over != 0 ? tag_over : 3);
            if (ack) begin
                put(m, 0, 0, 1, 0, 0, tag_over != 0 ? tag_over : 4, 1);
                if (m == 0) held0 = 1'b1; else held1 = 1'b1;
                return;
            end
            if (p == TRIES) begin
                quarters(m, 0, 0, 0, 1, 1, 1, 1, 0, 0, 7);
                put(m, 1, 0, 0, 1, 0, 7, 1);
                if (m == 0) held0 = 1'b0; else held1 = 1'b0;
                return;
            end
            if (m == 0) quarters(m, 0, 0, 0, 1, 1, 1, 1, 0, 0, tag_over != 0 ? tag_over : 5);
        end
    endtask

    task automatic chk(int m, ent_t e, logic s, logic o, logic d, logic t);
        checks++;
        if (s !== e.scl || o !== e.oe || d !== e.dn || t !== e.to) begin
            fails++;
            $display("FAIL %s%s dut%0d t=%0t got scl=%b oe=%b done=%b to=%b exp scl=%b oe=%b done=%b to=%b",
                     tname(int'(e.tag)), note, m, $time, s, o, d, t, e.scl, e.oe, e.dn, e.to);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            ent_t e0, e1;
            if (q0.size() > 0) e0 = q0.pop_front();
            else begin e0 = '0; e0.scl = !held0; e0.tag = held0 ? 4'd4 : 4'd1; end
            if (q1.size() > 0) e1 = q1.pop_front();
            else begin e1 = '0; e1.scl = !held1; e1.tag = held1 ? 4'd4 : 4'd1; end
            sl0 = e0.slv;
            sl1 = e1.slv;
            chk(0, e0, scl0, oe0, dn0, to0);
            chk(1, e1, scl1, oe1, dn1, to1);
        end
    end

    task automatic finish_up();
        ended = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic kick(int m, int ack_poll, int tag_over);
        @(posedge clk); #1;
        if (m == 0) st0 = 1'b1; else st1 = 1'b1;
        gen(m, ack_poll, tag_over);
        @(posedge clk); #1;
        st0 = 1'b0; st1 = 1'b0;
    endtask

    task automatic pulse(int m);
        @(posedge clk); #1;
        if (m == 0) st0 = 1'b1; else st1 = 1'b1;
        @(posedge clk); #1;
        st0 = 1'b0; st1 = 1'b0;
    endtask

    task automatic drain();
        while (q0.size() > 0 || q1.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        ent_t r;
        r = '0; r.scl = 1'b1; r.tag = 4'd1;
        repeat (4) begin
            @(negedge clk);
            chk(0, r, scl0, oe0, dn0, to0);   // R1 reset state
            chk(1, r, scl1, oe1, dn1, to1);
        end
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        kick(0, 3, 0);            // R2 R3 R5 R4: two misses, then ack
        drain();
        kick(0, 0, 0);            // R9 from held, then R7 timeout
        drain();
        note = " R8";
        kick(0, 4, 10);           // R10 full tries after timeout; R8 ignored start
        repeat (30) @(posedge clk);
        pulse(0);
        drain();
        note = "";
        kick(0, 1, 0);            // R9 immediate ack from held
        drain();
        kick(1, 2, 0);            // R6 repeated start between probes
        drain();
        kick(1, 0, 0);            // R9 then R7 in repeated-start mode
        drain();
        finish_up();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end
endmodule